// File: doc/BRIEF.md
# Double-Buffered Isochronous OUT Endpoint Buffer

This block sits between the packet engine of a full-speed USB device and a processor. It holds isochronous OUT payloads in two packet buffers. The buffers are filled and drained in strict alternation, so the processor reads packets in the order they arrived. The upstream engine delivers each packet as a start strobe, then a run of valid bytes, then an end strobe that carries a good/bad verdict.

The processor pops bytes through a byte-wide data port. It reads an 8-bit control/status word and clears the sticky event bits by writing ones. A single interrupt line, gated by a receive interrupt enable, reports finished and dropped packets. A good packet that finds no free buffer is dropped whole and flagged. A bad packet leaves no trace.

A zero-length packet occupies a buffer without data. Writing one to the packet-complete bit retires it.

Top module: `iso_out_ep`

## Requirements
- R1: After reset the status word is 0x00, the interrupt line is low and the data port reads 0x00.
- R2: A good packet is stored in the next buffer in alternation and sets packet-complete (bit 1). Its bytes are popped from the data port in arrival order, one per read strobe, and packets are read in the order they arrived.
- R3: A good packet that starts while both buffers hold packets is discarded and sets overflow (bit 2). The held packets are not altered.
- R4: A packet ended with a bad verdict changes no status bit and does not occupy a buffer.
- R5: Bits 1 and 2 clear when a one is written to them. A hardware set in the same cycle as the clear wins.
- R6: Bits 3, 4 and 5 always read 0, and writes to them have no effect.
- R7: The not-empty bit (bit 6) is 1 while the active buffer or the other buffer still holds unread bytes.
- R8: The short bit (bit 7) reports whether the active packet has fewer bytes than MAX_PKT. It is re-evaluated only when the active buffer is released, and it then describes the newly active buffer. A good packet landing in the non-active buffer clears it.
- R9: A zero-length packet shows bit 7 = 1 with bit 6 = 0. While it is active, read strobes return 0x00 and change nothing. Writing one to bit 1 retires it.
- R10: The service-request bit (bit 0) is 1 while any buffer holds a packet. It stays 1 until both buffers are released.
- R11: The interrupt line equals the receive interrupt enable AND (bit 1 OR bit 2).
- R12: A read strobe while no byte is available returns 0x00 and has no side effect.
- R13: Bytes beyond MAX_PKT in one packet are discarded. A packet of exactly MAX_PKT bytes is not short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_sop_i | input | 1 | Packet start strobe (carries no data) |
| rx_valid_i | input | 1 | Payload byte valid |
| rx_data_i | input | 8 | Payload byte |
| rx_eop_i | input | 1 | Packet end strobe (carries no data) |
| rx_good_i | input | 1 | Packet verdict, sampled with rx_eop_i (1 = good CRC) |
| rd_stb_i | input | 1 | Pop one byte from the data port |
| rd_data_o | output | 8 | Current byte of the active buffer, 0 when none |
| csr_we_i | input | 1 | Status word write strobe |
| csr_wdata_i | input | 8 | Status word write data (write-one-to-clear) |
| csr_o | output | 8 | Status word |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| irq_o | output | 1 | Endpoint interrupt request |

## Verification
The bench fills both buffers and then offers a third packet. A design that overwrote a held buffer instead of dropping the packet would return the third packet's bytes where the second's are expected. The short bit is checked across a drain boundary and on full-size, oversize and zero-length packets. A design that updated it on arrival, rather than on release, would show the wrong value while the first packet is still being read. The bench also issues a clear in the same cycle as a packet end, where wrong priority loses the packet-complete event. It pops the data port on a zero-length packet and on empty buffers, where a design that advanced its pointers would corrupt the next packet or retire the zero-length packet early.

// File: rtl/iso_out_pkg.sv
package iso_out_pkg;
  localparam int unsigned CSR_SRQ   = 0;
  localparam int unsigned CSR_DONE  = 1;
  localparam int unsigned CSR_OVF   = 2;
  localparam int unsigned CSR_NE    = 6;
  localparam int unsigned CSR_SHORT = 7;
endpackage

// File: rtl/iso_out_bufmem.sv
module iso_out_bufmem #(
  parameter int unsigned MAX_PKT = 256,
  parameter int unsigned AW      = $clog2(MAX_PKT)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic          wr_buf_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_buf_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem_q [MAX_PKT];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_buf_i == 1'(b))) mem_q[wr_addr_i] <= wr_data_i;
    end
    assign bank_rd[b] = mem_q[rd_addr_i];
  end

  assign rd_data_o = bank_rd[rd_buf_i];
endmodule

// File: rtl/iso_out_ctrl.sv
module iso_out_ctrl #(
  parameter int unsigned MAX_PKT = 256,
  parameter int unsigned AW      = $clog2(MAX_PKT),
  parameter int unsigned CW      = $clog2(MAX_PKT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_sop_i,
  input  logic          rx_valid_i,
  input  logic          rx_eop_i,
  input  logic          rx_good_i,
  input  logic          rd_stb_i,
  input  logic          zlp_ack_i,
  output logic          mem_we_o,
  output logic          mem_wbuf_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic          rd_buf_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_valid_o,
  output logic          pkt_done_o,
  output logic          pkt_drop_o,
  output logic          srq_o,
  output logic          ne_o,
  output logic          short_o,
  output logic          busy_o
);
  localparam logic [CW-1:0] MAX_CNT = CW'(MAX_PKT);

  logic          full_q [2];
  logic [CW-1:0] cnt_q  [2];
  logic          shrt_q [2];
  logic          full_n [2];
  logic [CW-1:0] cnt_n  [2];
  logic          shrt_n [2];
  logic          act_q, act_n, wsel_q, wsel_n;
  logic [CW-1:0] rptr_q, rptr_n, wcnt_q, wcnt_n;
  logic          busy_q, busy_n, keep_q, keep_n, short_q, short_n;
  logic          act_valid, rd_fire, last_rd, zlp_rel, fin;

  assign act_valid  = full_q[act_q] && (rptr_q < cnt_q[act_q]);
  assign rd_fire    = rd_stb_i && act_valid;
  assign last_rd    = rd_fire && ((rptr_q + 1'b1) == cnt_q[act_q]);
  assign zlp_rel    = zlp_ack_i && full_q[act_q] && (cnt_q[act_q] == '0);
  assign fin        = busy_q && rx_eop_i;
  assign pkt_done_o = fin && keep_q && rx_good_i;
  assign pkt_drop_o = fin && !keep_q && rx_good_i;
  assign mem_we_o   = busy_q && keep_q && rx_valid_i && (wcnt_q < MAX_CNT);

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      full_n[b] = full_q[b];
      cnt_n[b]  = cnt_q[b];
      shrt_n[b] = shrt_q[b];
    end
    act_n   = act_q;
    wsel_n  = wsel_q;
    rptr_n  = rptr_q;
    short_n = short_q;
    busy_n  = busy_q;
    keep_n  = keep_q;
    wcnt_n  = wcnt_q;

    if (rd_fire) rptr_n = rptr_q + 1'b1;
    // release active buffer: short flag follows the newly active one
    if (last_rd || zlp_rel) begin
      full_n[act_q] = 1'b0;
      rptr_n        = '0;
      act_n         = ~act_q;
      short_n       = full_q[~act_q] ? shrt_q[~act_q] : 1'b0;
    end

    if (mem_we_o) wcnt_n = wcnt_q + 1'b1;
    if (rx_sop_i) begin
      busy_n = 1'b1;
      keep_n = !full_q[wsel_q];
      wcnt_n = '0;
    end else if (fin) begin
      busy_n = 1'b0;
    end

    if (pkt_done_o) begin
      full_n[wsel_q] = 1'b1;
      cnt_n[wsel_q]  = wcnt_q;
      shrt_n[wsel_q] = wcnt_q < MAX_CNT;
      wsel_n         = ~wsel_q;
      short_n        = (wsel_q == act_n) ? (wcnt_q < MAX_CNT) : 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++) begin
        full_q[b] <= 1'b0;
        cnt_q[b]  <= '0;
        shrt_q[b] <= 1'b0;
      end
      act_q   <= 1'b0;
      wsel_q  <= 1'b0;
      rptr_q  <= '0;
      wcnt_q  <= '0;
      busy_q  <= 1'b0;
      keep_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        full_q[b] <= full_n[b];
        cnt_q[b]  <= cnt_n[b];
        shrt_q[b] <= shrt_n[b];
      end
      act_q   <= act_n;
      wsel_q  <= wsel_n;
      rptr_q  <= rptr_n;
      wcnt_q  <= wcnt_n;
      busy_q  <= busy_n;
      keep_q  <= keep_n;
      short_q <= short_n;
    end
  end

  assign mem_wbuf_o  = wsel_q;
  assign mem_waddr_o = wcnt_q[AW-1:0];
  assign rd_buf_o    = act_q;
  assign rd_addr_o   = rptr_q[AW-1:0];
  assign rd_valid_o  = act_valid;
  assign srq_o       = full_q[0] || full_q[1];
  assign ne_o        = act_valid || (full_q[~act_q] && (cnt_q[~act_q] != '0));
  assign short_o     = short_q;
  assign busy_o      = busy_q;
endmodule

// File: rtl/iso_out_csr.sv
module iso_out_csr
  import iso_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pkt_done_i,
  input  logic       pkt_drop_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       irq_en_i,
  input  logic       srq_i,
  input  logic       ne_i,
  input  logic       short_i,
  output logic [7:0] csr_o,
  output logic       irq_o
);
  logic done_q, ovf_q;

  // hardware set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= pkt_done_i || (done_q && !(we_i && wdata_i[CSR_DONE]));
      ovf_q  <= pkt_drop_i || (ovf_q && !(we_i && wdata_i[CSR_OVF]));
    end
  end

  always_comb begin
    csr_o            = '0;
    csr_o[CSR_SRQ]   = srq_i;
    csr_o[CSR_DONE]  = done_q;
    csr_o[CSR_OVF]   = ovf_q;
    csr_o[CSR_NE]    = ne_i;
    csr_o[CSR_SHORT] = short_i;
  end

  assign irq_o = irq_en_i && (done_q || ovf_q);
endmodule

// File: rtl/iso_out_ep.sv
module iso_out_ep
  import iso_out_pkg::*;
#(
  parameter int unsigned MAX_PKT = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_sop_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_eop_i,
  input  logic       rx_good_i,
  input  logic       rd_stb_i,
  output logic [7:0] rd_data_o,
  input  logic       csr_we_i,
  input  logic [7:0] csr_wdata_i,
  output logic [7:0] csr_o,
  input  logic       rx_irq_en_i,
  output logic       irq_o
);
  localparam int unsigned AW = $clog2(MAX_PKT);
  localparam int unsigned CW = $clog2(MAX_PKT + 1);

  logic          mem_we, mem_wbuf, rd_buf, rd_valid;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic [7:0]    mem_rdata;
  logic          pkt_done, pkt_drop, srq, ne, short_f, rx_busy;

  iso_out_ctrl #(.MAX_PKT(MAX_PKT), .AW(AW), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_sop_i   (rx_sop_i),
    .rx_valid_i (rx_valid_i),
    .rx_eop_i   (rx_eop_i),
    .rx_good_i  (rx_good_i),
    .rd_stb_i   (rd_stb_i),
    .zlp_ack_i  (csr_we_i && csr_wdata_i[CSR_DONE]),
    .mem_we_o   (mem_we),
    .mem_wbuf_o (mem_wbuf),
    .mem_waddr_o(mem_waddr),
    .rd_buf_o   (rd_buf),
    .rd_addr_o  (rd_addr),
    .rd_valid_o (rd_valid),
    .pkt_done_o (pkt_done),
    .pkt_drop_o (pkt_drop),
    .srq_o      (srq),
    .ne_o       (ne),
    .short_o    (short_f),
    .busy_o     (rx_busy)
  );

  iso_out_bufmem #(.MAX_PKT(MAX_PKT), .AW(AW)) u_mem (
    .clk_i    (clk_i),
    .wr_en_i  (mem_we),
    .wr_buf_i (mem_wbuf),
    .wr_addr_i(mem_waddr),
    .wr_data_i(rx_data_i),
    .rd_buf_i (rd_buf),
    .rd_addr_i(rd_addr),
    .rd_data_o(mem_rdata)
  );

  iso_out_csr u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pkt_done_i(pkt_done),
    .pkt_drop_i(pkt_drop),
    .we_i      (csr_we_i),
    .wdata_i   (csr_wdata_i),
    .irq_en_i  (rx_irq_en_i),
    .srq_i     (srq),
    .ne_i      (ne),
    .short_i   (short_f),
    .csr_o     (csr_o),
    .irq_o     (irq_o)
  );

  assign rd_data_o = rd_valid ? mem_rdata : 8'h00;
endmodule

// File: rtl/iso_out_ep_chk.sv
module iso_out_ep_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_eop_i,
  input logic       rx_good_i,
  input logic       rd_stb_i,
  input logic       csr_we_i,
  input logic [7:0] csr_wdata_i,
  input logic [7:0] csr_o,
  input logic [7:0] rd_data_o,
  input logic       rx_irq_en_i,
  input logic       irq_o,
  input logic       busy_i
);
  assert_pkt_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rx_eop_i && rx_good_i |=> csr_o[1] || csr_o[2]);

  assert_bad_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rx_eop_i && !rx_good_i && !rd_stb_i && !csr_we_i |=> $stable(csr_o));

  assert_ovf_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csr_o[2]) |-> $past(csr_we_i && csr_wdata_i[2]));

  assert_zlp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[7] && !csr_o[6] && rd_stb_i && !csr_we_i && !(busy_i && rx_eop_i) |=> $stable(csr_o));

  assert_zlp_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[7] && !csr_o[6] |-> rd_data_o == 8'h00);

  assert_srq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csr_o[0]) |-> $past(rd_stb_i || (csr_we_i && csr_wdata_i[1])));

  assert_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[1] || csr_o[2]) && rx_irq_en_i |-> irq_o);

  assert_empty_data_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_o[0] |-> rd_data_o == 8'h00);
endmodule

bind iso_out_ep iso_out_ep_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_eop_i   (rx_eop_i),
  .rx_good_i  (rx_good_i),
  .rd_stb_i   (rd_stb_i),
  .csr_we_i   (csr_we_i),
  .csr_wdata_i(csr_wdata_i),
  .csr_o      (csr_o),
  .rd_data_o  (rd_data_o),
  .rx_irq_en_i(rx_irq_en_i),
  .irq_o      (irq_o),
  .busy_i     (rx_busy)
);

// File: tb/iso_out_ep_test.sv
module iso_out_ep_test;
  localparam int unsigned MAXP = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_sop_i = 1'b0, rx_valid_i = 1'b0, rx_eop_i = 1'b0, rx_good_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rd_stb_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       csr_we_i = 1'b0;
  logic [7:0] csr_wdata_i = '0;
  logic [7:0] csr_o;
  logic       rx_irq_en_i = 1'b1;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  iso_out_ep #(.MAX_PKT(MAXP)) uut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int n, input logic [7:0] base, input logic good, input logic clr_at_end);
    @(negedge clk_i) rx_sop_i = 1'b1;
    @(negedge clk_i) rx_sop_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      rx_valid_i = 1'b1;
      rx_data_i  = base + 8'(k);
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0;
    rx_eop_i   = 1'b1;
    rx_good_i  = good;
    if (clr_at_end) begin
      csr_we_i    = 1'b1;
      csr_wdata_i = 8'h02;
    end
    @(negedge clk_i);
    rx_eop_i  = 1'b0;
    rx_good_i = 1'b0;
    csr_we_i  = 1'b0;
  endtask

  task automatic pop(input string req, input logic [7:0] exp);
    chk(req, rd_data_o, exp);
    rd_stb_i = 1'b1;
    @(negedge clk_i) rd_stb_i = 1'b0;
  endtask

  task automatic wr_csr(input logic [7:0] v);
    csr_we_i    = 1'b1;
    csr_wdata_i = v;
    @(negedge clk_i) csr_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 csr", csr_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 data", rd_data_o, 8'h00);
  endtask

  task automatic t_empty_read;
    pop("R12 empty data", 8'h00);
    chk("R12 csr after empty read", csr_o, 8'h00);
  endtask

  task automatic t_single;
    send_pkt(3, 8'h10, 1'b1, 1'b0);
    chk("R2 R8 R10 csr after short pkt", csr_o, 8'hC3);
    chk("R11 irq enabled", {7'd0, irq_o}, 8'h01);
    pop("R2 byte0", 8'h10);
    chk("R7 ne mid packet", csr_o, 8'hC3);
    pop("R2 byte1", 8'h11);
    pop("R2 byte2", 8'h12);
    chk("R10 csr after drain", csr_o, 8'h02);
    rx_irq_en_i = 1'b0;
    #1 chk("R11 irq disabled", {7'd0, irq_o}, 8'h00);
    rx_irq_en_i = 1'b1;
    wr_csr(8'h02);
    chk("R5 done cleared", csr_o, 8'h00);
    chk("R11 irq after clear", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_pingpong_ovf;
    send_pkt(8, 8'h20, 1'b1, 1'b0);
    chk("R13 full-size not short", csr_o, 8'h43);
    send_pkt(2, 8'h40, 1'b1, 1'b0);
    chk("R8 short cleared by non-active arrival", csr_o, 8'h43);
    send_pkt(4, 8'h60, 1'b1, 1'b0);
    chk("R3 overflow flagged", csr_o, 8'h47);
    for (int k = 0; k < 4; k++) pop("R2 first pkt", 8'h20 + 8'(k));
    chk("R8 short unchanged mid read", csr_o, 8'h47);
    for (int k = 4; k < 8; k++) pop("R2 first pkt", 8'h20 + 8'(k));
    chk("R8 R7 R10 switch to second buffer", csr_o, 8'hC7);
    pop("R3 second pkt kept", 8'h40);
    pop("R3 second pkt kept", 8'h41);
    chk("R10 both drained", csr_o, 8'h06);
    chk("R12 data when empty", rd_data_o, 8'h00);
    wr_csr(8'h04);
    chk("R5 ovf cleared only", csr_o, 8'h02);
    wr_csr(8'h02);
    chk("R5 all cleared", csr_o, 8'h00);
  endtask

  task automatic t_bad;
    send_pkt(3, 8'h55, 1'b0, 1'b0);
    chk("R4 bad pkt no status", csr_o, 8'h00);
    chk("R4 bad pkt no data", rd_data_o, 8'h00);
    send_pkt(2, 8'h70, 1'b1, 1'b0);
    pop("R4 next good pkt", 8'h70);
    pop("R4 next good pkt", 8'h71);
    wr_csr(8'h02);
    chk("R4 clean", csr_o, 8'h00);
  endtask

  task automatic t_long;
    send_pkt(10, 8'h80, 1'b1, 1'b0);
    chk("R13 oversize csr", csr_o, 8'h43);
    for (int k = 0; k < 8; k++) pop("R13 oversize bytes", 8'h80 + 8'(k));
    chk("R13 extra bytes discarded", csr_o, 8'h02);
    pop("R12 read past end", 8'h00);
    chk("R12 csr unchanged", csr_o, 8'h02);
    wr_csr(8'h02);
  endtask

  task automatic t_zlp;
    send_pkt(0, 8'h00, 1'b1, 1'b0);
    chk("R9 zlp csr", csr_o, 8'h83);
    pop("R9 zlp data zero", 8'h00);
    chk("R9 zlp read no effect", csr_o, 8'h83);
    wr_csr(8'h02);
    chk("R9 zlp retired", csr_o, 8'h00);
  endtask

  task automatic t_setwins;
    send_pkt(1, 8'h91, 1'b1, 1'b1);
    chk("R5 set beats clear", csr_o, 8'hC3);
    pop("R2 single byte", 8'h91);
    chk("R10 drained", csr_o, 8'h02);
    wr_csr(8'h38);
    chk("R6 reserved write ignored", csr_o, 8'h02);
    wr_csr(8'h02);
    chk("R6 reserved zero", csr_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_empty_read();
    t_single();
    t_pingpong_ovf();
    t_bad();
    t_long();
    t_zlp();
    t_setwins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule